// File: doc/BRIEF.md
# Wired-OR Bus Bridge Arithmetic Unit

This block is a 16-bit arithmetic datapath placed between a shared read bus and a write bus. In each clock step the surrounding logic raises individual read pulses and write pulses. Several external subsystems can present a word on the read bus. The unit merges that word with any number of its own read sources by bitwise inclusive OR and forwards the result onto the write bus. Its read sources are its registers, the adder output and a set of constant injections. Write pulses then load the B, X, Y and carry-in registers from the merged word on the clock edge that ends the step.

The adder output is combinational. It is the ones-complement sum of X, Y and the carry-in flip-flop, with end-around carry. When no external subsystem drives the read bus, the unit supplies zeros as the external term of the merge. More than one external driver in the same step is an error, and the unit raises a flag for it.

Top module: `alu_bridge_unit`

## Requirements
- R1: A synchronous active-high `rst` clears B, X, Y and carry-in to zero at the next edge. It overrides any write pulse in the same step.
- R2: With no `ext_valid` bit set and no `rd_sel` bit set, `wbus` is all zeros.
- R3: `bus_conflict` is high in exactly those steps where two or more `ext_valid` bits are set. In such a step the external term is the OR of every driving word.
- R4: The word of a single valid external driver appears on `wbus`, ORed with the active internal sources.
- R5: Each set bit of `rd_sel` ORs one source into `wbus`, and any subset may be set at once. The sources by bit are: 0 B, 1 bitwise complement of B, 2 sum U, 3 B masked to 0o040000, 4 0o000001, 5 0o177776, 6 0o000002, 7 0o000022, 8 0o000024, 9 0o002000, 10 0o100000.
- R6: `sum_u` equals ((s mod 2^16) + (s div 2^16)) mod 2^16, where s = X + Y + CI.
- R7: Reads precede writes. A write pulse stores the `wbus` value formed from the register contents held before the edge, including U.
- R8: `wr_sel` bits act at the edge as follows. Bit 0 clears X, Y and CI. Bit 1 loads B. Bit 2 loads CI from `wbus` bit 0. Bit 3 loads Y and clears X and CI. Bit 4 loads X. Bit 5 loads Y and leaves X and CI unchanged.
- R9: When pulses meet, a load takes precedence over a clear of the same register.
- R10: With `wr_sel` all zero and `rst` low, B, X, Y and CI hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_valid | input | N_EXT | One bit per external read-bus driver |
| ext_word | input | N_EXT*16 | Words of the external drivers, driver i at bits [16i+15:16i] |
| rd_sel | input | 11 | Internal read pulses |
| wr_sel | input | 6 | Write pulses |
| wbus | output | 16 | Merged write-bus word |
| sum_u | output | 16 | Ones-complement sum of X, Y and CI |
| reg_b | output | 16 | B register |
| reg_x | output | 16 | X register |
| reg_y | output | 16 | Y register |
| reg_ci | output | 1 | Carry-in flip-flop |
| bus_conflict | output | 1 | Two or more external drivers active |

## Verification
The bench applies all 2048 subsets of read pulses while X is reloaded from the merged word in each step. A mapping with a wrong constant, a complement of B taken from the wrong register, or a source that is overwritten instead of ORed would miscompare quickly, and so would a sum read after the write. All 64 write-pulse combinations are run against random bus words to expose clear-versus-load priority errors, for example a general clear that wipes out a same-step Y load. Sum corners cover the end-around carry at 0xFFFF+1, all ones plus all ones plus carry, and negative zero. All 16 external-driver patterns are applied to catch a conflict flag with an off-by-one threshold.

// File: rtl/alu_bridge_pkg.sv
`timescale 1ns/1ps
package alu_bridge_pkg;

    localparam int WORD_W = 16;
    localparam int NUM_RD = 11;
    localparam int NUM_WR = 6;

    typedef logic [WORD_W-1:0] word_t;

    // read pulse positions in rd_sel
    typedef enum int unsigned {
        RD_B      = 0,
        RD_BINV   = 1,
        RD_SUM    = 2,
        RD_B14    = 3,
        RD_ONE    = 4,
        RD_ONE_C  = 5,
        RD_TWO    = 6,
        RD_O22    = 7,
        RD_O24    = 8,
        RD_O2000  = 9,
        RD_SIGN   = 10
    } rd_idx_e;

    // write pulse positions in wr_sel
    typedef enum int unsigned {
        WR_CLR    = 0,
        WR_B      = 1,
        WR_CI     = 2,
        WR_Y      = 3,
        WR_X      = 4,
        WR_YONLY  = 5
    } wr_idx_e;

    typedef struct packed {
        word_t b;
        word_t x;
        word_t y;
        logic  ci;
    } regs_t;

    localparam word_t MASK_B14 = word_t'(1) << (WORD_W - 2);
    localparam word_t K_SIGN   = word_t'(1) << (WORD_W - 1);
    localparam word_t K_ONE    = word_t'(1);
    localparam word_t K_ONE_C  = ~word_t'(1);
    localparam word_t K_TWO    = word_t'(2);
    localparam word_t K_O22    = word_t'(18);
    localparam word_t K_O24    = word_t'(20);
    localparam word_t K_O2000  = word_t'(1024);

    // ones-complement add with end-around carry
    function automatic word_t oc_add(word_t a, word_t b, logic cin);
        logic [WORD_W:0] s;
        s = {1'b0, a} + {1'b0, b} + {{WORD_W{1'b0}}, cin};
        return s[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, s[WORD_W]};
    endfunction

endpackage

// File: rtl/alu_rd_merge.sv
`timescale 1ns/1ps
module alu_rd_merge
    import alu_bridge_pkg::*;
#(
    parameter int N_EXT = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_EXT-1:0]        ext_valid,
    input  logic [N_EXT*WORD_W-1:0] ext_word,
    input  logic [NUM_RD-1:0]       rd_sel,
    input  word_t                   b_q,
    input  word_t                   sum_u,
    output word_t                   wbus,
    output logic                    conflict
);
    localparam int CNT_W = $clog2(N_EXT + 1);

    word_t ext_gated [N_EXT];
    word_t src [NUM_RD];
    word_t ext_or;
    word_t int_or;
    logic [CNT_W-1:0] drv_cnt;

    genvar gi;
    generate
        for (gi = 0; gi < N_EXT; gi++) begin : g_ext
            assign ext_gated[gi] = ext_valid[gi] ? ext_word[gi*WORD_W +: WORD_W] : '0;
        end
    endgenerate

    always_comb begin
        ext_or  = '0;
        drv_cnt = '0;
        for (int i = 0; i < N_EXT; i++) begin
            ext_or  = ext_or | ext_gated[i];
            drv_cnt = drv_cnt + CNT_W'(ext_valid[i]);
        end
    end

    assign conflict = (drv_cnt > CNT_W'(1));

    always_comb begin
        src[RD_B]     = b_q;
        src[RD_BINV]  = ~b_q;
        src[RD_SUM]   = sum_u;
        src[RD_B14]   = b_q & MASK_B14;
        src[RD_ONE]   = K_ONE;
        src[RD_ONE_C] = K_ONE_C;
        src[RD_TWO]   = K_TWO;
        src[RD_O22]   = K_O22;
        src[RD_O24]   = K_O24;
        src[RD_O2000] = K_O2000;
        src[RD_SIGN]  = K_SIGN;
    end

    always_comb begin
        int_or = '0;
        for (int k = 0; k < NUM_RD; k++) begin
            if (rd_sel[k]) int_or = int_or | src[k];
        end
    end

    assign wbus = ext_or | int_or;

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (ext_valid == '0 && rd_sel == '0) |-> (wbus == '0));

    p_single_drv_r3: assert property (@(posedge clk) disable iff (rst)
        ($countones(ext_valid) <= 1) |-> !conflict);

    p_forward_r4: assert property (@(posedge clk) disable iff (rst)
        (ext_valid == N_EXT'(1) && rd_sel == '0) |-> (wbus == ext_word[WORD_W-1:0]));

endmodule

// File: rtl/alu_oc_adder.sv
`timescale 1ns/1ps
module alu_oc_adder
    import alu_bridge_pkg::*;
(
    input  word_t x_q,
    input  word_t y_q,
    input  logic  ci_q,
    output word_t sum_u
);
    assign sum_u = oc_add(x_q, y_q, ci_q);

    always_comb begin
        if (x_q == ~y_q && !ci_q) begin
            p_neg_zero_r6: assert (sum_u == '1);
        end
    end

endmodule

// File: rtl/alu_reg_bank.sv
`timescale 1ns/1ps
module alu_reg_bank
    import alu_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_WR-1:0] wr_sel,
    input  word_t             wbus,
    output regs_t             regs_q
);
    regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        // clears first, loads afterwards so loads win
        if (wr_sel[WR_CLR]) begin
            regs_d.x  = '0;
            regs_d.y  = '0;
            regs_d.ci = 1'b0;
        end
        if (wr_sel[WR_Y]) begin
            regs_d.x  = '0;
            regs_d.ci = 1'b0;
        end
        if (wr_sel[WR_Y] || wr_sel[WR_YONLY]) regs_d.y = wbus;
        if (wr_sel[WR_X])  regs_d.x  = wbus;
        if (wr_sel[WR_CI]) regs_d.ci = wbus[0];
        if (wr_sel[WR_B])  regs_d.b  = wbus;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (regs_q == '0));

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == NUM_WR'(1)) |=> (regs_q.x == '0 && regs_q.y == '0 && !regs_q.ci));

    p_bload_r8: assert property (@(posedge clk) disable iff (rst)
        wr_sel[WR_B] |=> (regs_q.b == $past(wbus)));

    p_yload_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_sel[WR_CLR] && wr_sel[WR_YONLY]) |=> (regs_q.y == $past(wbus)));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == '0) |=> $stable(regs_q));

endmodule

// File: rtl/alu_bridge_unit.sv
`timescale 1ns/1ps
module alu_bridge_unit
    import alu_bridge_pkg::*;
#(
    parameter int N_EXT = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_EXT-1:0]        ext_valid,
    input  logic [N_EXT*WORD_W-1:0] ext_word,
    input  logic [NUM_RD-1:0]       rd_sel,
    input  logic [NUM_WR-1:0]       wr_sel,
    output logic [WORD_W-1:0]       wbus,
    output logic [WORD_W-1:0]       sum_u,
    output logic [WORD_W-1:0]       reg_b,
    output logic [WORD_W-1:0]       reg_x,
    output logic [WORD_W-1:0]       reg_y,
    output logic                    reg_ci,
    output logic                    bus_conflict
);
    regs_t regs_q;
    word_t sum_w;
    word_t bus_w;

    alu_oc_adder u_adder (
        .x_q   (regs_q.x),
        .y_q   (regs_q.y),
        .ci_q  (regs_q.ci),
        .sum_u (sum_w)
    );

    alu_rd_merge #(.N_EXT(N_EXT)) u_merge (
        .clk       (clk),
        .rst       (rst),
        .ext_valid (ext_valid),
        .ext_word  (ext_word),
        .rd_sel    (rd_sel),
        .b_q       (regs_q.b),
        .sum_u     (sum_w),
        .wbus      (bus_w),
        .conflict  (bus_conflict)
    );

    alu_reg_bank u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_sel (wr_sel),
        .wbus   (bus_w),
        .regs_q (regs_q)
    );

    assign wbus   = bus_w;
    assign sum_u  = sum_w;
    assign reg_b  = regs_q.b;
    assign reg_x  = regs_q.x;
    assign reg_y  = regs_q.y;
    assign reg_ci = regs_q.ci;

    p_sum_to_x_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == NUM_WR'(16) && rd_sel == NUM_RD'(4) && ext_valid == '0)
        |=> (reg_x == $past(sum_u)));

endmodule

// File: tb/tb_alu_bridge_unit.sv
`timescale 1ns/1ps
module tb_alu_bridge_unit;

    localparam int NE = 4;
    localparam int CYCLE_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [NE-1:0]    ext_valid = '0;
    logic [NE*16-1:0] ext_word = '0;
    logic [10:0] rd_sel = '0;
    logic [5:0]  wr_sel = '0;
    logic [15:0] wbus, sum_u, reg_b, reg_x, reg_y;
    logic        reg_ci, bus_conflict;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    logic [15:0] mb = '0, mx = '0, my = '0;
    logic        mci = 1'b0;

    always #10 clk = ~clk;

    alu_bridge_unit #(.N_EXT(NE)) dut (
        .clk(clk), .rst(rst), .ext_valid(ext_valid), .ext_word(ext_word),
        .rd_sel(rd_sel), .wr_sel(wr_sel), .wbus(wbus), .sum_u(sum_u),
        .reg_b(reg_b), .reg_x(reg_x), .reg_y(reg_y), .reg_ci(reg_ci),
        .bus_conflict(bus_conflict)
    );

    function automatic logic [15:0] ref_sum(logic [15:0] a, logic [15:0] b, logic c);
        int s;
        s = int'(a) + int'(b) + int'(c);
        return 16'(((s & 'hFFFF) + (s >> 16)) & 'hFFFF);
    endfunction

    function automatic logic [15:0] ref_bus(logic [NE-1:0] ev, logic [NE*16-1:0] w,
                                            logic [10:0] rd, logic [15:0] u);
        logic [15:0] acc;
        acc = '0;
        for (int i = 0; i < NE; i++) if (ev[i]) acc |= w[i*16 +: 16];
        if (rd[0])  acc |= mb;
        if (rd[1])  acc |= ~mb;
        if (rd[2])  acc |= u;
        if (rd[3])  acc |= mb & 16'o040000;
        if (rd[4])  acc |= 16'o000001;
        if (rd[5])  acc |= 16'o177776;
        if (rd[6])  acc |= 16'o000002;
        if (rd[7])  acc |= 16'o000022;
        if (rd[8])  acc |= 16'o000024;
        if (rd[9])  acc |= 16'o002000;
        if (rd[10]) acc |= 16'o100000;
        return acc;
    endfunction

    task automatic chk(input string tag, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag);
        chk(tag, "reg_b", reg_b, mb);
        chk(tag, "reg_x", reg_x, mx);
        chk(tag, "reg_y", reg_y, my);
        chk(tag, "reg_ci", {15'd0, reg_ci}, {15'd0, mci});
    endtask

    task automatic step(input logic [NE-1:0] ev, input logic [NE*16-1:0] w,
                        input logic [10:0] rd, input logic [5:0] wr,
                        input string tw, input string tr);
        logic [15:0] eu, eb;
        logic ec;
        @(negedge clk);
        ext_valid = ev; ext_word = w; rd_sel = rd; wr_sel = wr;
        #2;
        eu = ref_sum(mx, my, mci);
        eb = ref_bus(ev, w, rd, eu);
        ec = ($countones(ev) > 1);
        chk(tw, "wbus", wbus, eb);
        chk("R6", "sum_u", sum_u, eu);
        chk("R3", "bus_conflict", {15'd0, bus_conflict}, {15'd0, ec});
        // requirement-level model: clears, then loads
        if (wr[0]) begin mx = '0; my = '0; mci = 1'b0; end
        if (wr[3]) begin mx = '0; mci = 1'b0; end
        if (wr[3] || wr[5]) my = eb;
        if (wr[4]) mx = eb;
        if (wr[2]) mci = eb[0];
        if (wr[1]) mb = eb;
        @(posedge clk);
        #1;
        chk_regs(tr);
    endtask

    task automatic load_xyc(input logic [15:0] x, input logic [15:0] y, input logic c);
        step(4'b0001, {48'd0, x}, '0, 6'b010000, "R4", "R8");
        step(4'b0010, {32'd0, y, 16'd0}, '0, 6'b100000, "R4", "R8");
        step(4'b0100, {15'd0, c, 32'd0}, '0, 6'b000100, "R4", "R8");
    endtask

    initial begin
        repeat (CYCLE_LIMIT) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk_regs("R1");
        @(negedge clk);
        rst = 1'b0;

        // R2 idle, R10 hold
        step('0, '0, '0, '0, "R2", "R10");

        // R8 B load from a single driver
        step(4'b1000, {16'o052525, 48'd0}, '0, 6'b000010, "R4", "R8");

        // R5 every read subset, X reloaded each step (R7 read before write)
        for (int r = 0; r < 2048; r++) begin
            logic [NE*16-1:0] w;
            logic [NE-1:0] ev;
            w  = {$urandom, $urandom};
            ev = (r % 3 == 0) ? '0 : NE'(1 << (r % NE));
            step(ev, w, 11'(r), 6'b010000, "R5", "R7");
            if (r % 256 == 0)
                step('0, {$urandom, $urandom}, '0, 6'b000010 | 6'b001000, "R2", "R8");
        end

        // R3 all external driver patterns
        for (int v = 0; v < 16; v++) begin
            step(NE'(v), {$urandom, $urandom}, '0, '0, "R3", "R10");
        end

        // R9 all write pulse combinations
        for (int k = 0; k < 128; k++) begin
            step(NE'(1 << (k % NE)), {$urandom, $urandom}, 11'($urandom),
                 6'(k % 64), "R4", "R9");
        end

        // R6 sum corners then random
        load_xyc(16'hFFFF, 16'h0001, 1'b0);
        step('0, '0, 11'b00000000100, '0, "R6", "R10");
        load_xyc(16'hFFFF, 16'hFFFF, 1'b1);
        step('0, '0, 11'b00000000100, '0, "R6", "R10");
        load_xyc(16'h1234, 16'hEDCB, 1'b0);
        step('0, '0, 11'b00000000100, '0, "R6", "R10");
        load_xyc(16'h7FFF, 16'h8000, 1'b1);
        step('0, '0, 11'b00000000100, '0, "R6", "R10");
        for (int n = 0; n < 1500; n++) begin
            load_xyc(16'($urandom), 16'($urandom), 1'($urandom));
            step('0, '0, 11'b00000000100, '0, "R6", "R10");
        end

        // R7 sum into X and B|1 into B in one step
        step('0, '0, 11'b00000000100, 6'b010000, "R6", "R7");
        step('0, '0, 11'b00000010001, 6'b000010, "R5", "R7");

        // R1 mid-run reset wins over loads
        load_xyc(16'h5A5A, 16'hA5A5, 1'b1);
        @(negedge clk);
        rst = 1'b1; ext_valid = 4'b0001; ext_word = {48'd0, 16'hBEEF}; wr_sel = 6'b111111;
        @(posedge clk);
        #1;
        mb = '0; mx = '0; my = '0; mci = 1'b0;
        chk_regs("R1");
        @(negedge clk);
        rst = 1'b0; wr_sel = '0; ext_valid = '0;
        step('0, '0, '0, '0, "R2", "R10");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule